// File: doc/BRIEF.md
# PWM Channel Timebase Supervisor with Switching Delay

This block drives one PWM channel output. A raw PWM request comes in, and every edge of that request reaches the channel drive only after a programmable number of PWM timebase periods. A 3-bit code sets the delay in steps of sixteen periods. Code zero passes the request through with no added delay.

The timebase is one of two sources. The first is the rising edges of an external reference clock, which is sampled in the system clock domain. The second is a single-cycle tick from an internal calibrated oscillator. A select bit picks the source.

While the external reference is in use, its frequency is checked. The block counts reference edges over a fixed window of system clock cycles. A count below the lower limit or above the upper limit raises a sticky clock-fail flag. While that flag is set, the PWM path is bypassed and the channel follows a static On bit. The flag is cleared only by a clear strobe. All pins are plain level or strobe signals. There is no streaming handshake, so the block never applies or accepts back-pressure.

Top module: `pwm_clkmon_delay`

## Requirements
- R1: After reset, `chan_drv_o` is 0 and `clk_fail_o` is 0.
- R2: With `delay_code_i` = 0 and no clock failure, a change of `pwm_req_i` appears on `chan_drv_o` two clock cycles later.
- R3: With `delay_code_i` = k (1 to 7), a request edge appears on `chan_drv_o` one cycle after the (16·k)-th timebase tick that follows it, and not earlier.
- R4: Every edge of `pwm_req_i` restarts the delay count, so ticks counted before it are discarded.
- R5: With `sel_int_i` = 1, only `int_tick_i` pulses advance the delay and reference edges have no effect. With `sel_int_i` = 0, rising edges of `ref_clk_i` advance it.
- R6: With `sel_int_i` = 0, a window of `WIN_CYC` cycles holding fewer than `MIN_EDGES` reference rising edges sets `clk_fail_o`.
- R7: With `sel_int_i` = 0, a window holding more than `MAX_EDGES` reference rising edges sets `clk_fail_o`.
- R8: A reference whose edge count stays within [`MIN_EDGES`, `MAX_EDGES`] never sets `clk_fail_o`.
- R9: `clk_fail_o` stays 1 until `fail_clr_i` is pulsed. With `sel_int_i` = 1, a pulse clears it on the next cycle.
- R10: While `sel_int_i` = 1, the reference input is not monitored and a stopped reference does not set `clk_fail_o`.
- R11: While `clk_fail_o` = 1, `chan_drv_o` equals `on_i` from the previous cycle, and the PWM request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | External reference clock, sampled through a two-stage synchronizer |
| int_tick_i | input | 1 | One-cycle pulse per internal calibrated clock period |
| sel_int_i | input | 1 | 1 selects the internal tick as timebase, 0 selects the reference |
| delay_code_i | input | 3 | Delay in units of 16 timebase periods |
| on_i | input | 1 | Static drive level used while the clock has failed |
| pwm_req_i | input | 1 | Raw PWM request level |
| fail_clr_i | input | 1 | Strobe that clears the sticky clock-fail flag |
| chan_drv_o | output | 1 | Delayed channel drive |
| clk_fail_o | output | 1 | Sticky reference clock failure flag |

## Verification
The assertions assume that `int_tick_i` is a pulse no longer than one cycle. They also assume that `delay_code_i` is not changed while a delay is counting, and that a clear strobe given with the internal clock selected leaves no window evaluation pending. The bench follows these rules. Every input changes on the falling clock edge. Ticks are single-cycle pulses spaced two cycles apart, and none coincides with a request edge. The delay code is changed only while the delay path is idle. Fail flags are cleared only with `sel_int_i` held at 1. The reference is generated with half-periods of 2, 8 or 32 cycles, so each window count lies clearly inside or clearly outside the limits.

// File: rtl/pwm_mon_pkg.sv
package pwm_mon_pkg;
  // Source of the PWM timebase
  typedef enum logic {
    TB_REF = 1'b0,
    TB_INT = 1'b1
  } tb_src_e;

  // Width needed to hold a count of 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], async_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/ref_freq_window.sv
module ref_freq_window
  import pwm_mon_pkg::*;
#(
  parameter int WIN_CYC   = 256,
  parameter int MIN_EDGES = 8,
  parameter int MAX_EDGES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic fail_o
);
  localparam int WIN_W  = cnt_width(WIN_CYC - 1);
  localparam int EDGE_W = cnt_width(MAX_EDGES + 1);
  localparam logic [EDGE_W-1:0] SAT = EDGE_W'(MAX_EDGES + 1);

  logic [WIN_W-1:0]  win_q;
  logic [EDGE_W-1:0] edge_q;
  logic              fail_q;
  logic              win_end;
  logic              bad;

  assign win_end = (win_q == WIN_W'(WIN_CYC - 1));
  assign bad     = win_end && !hold_i &&
                   ((edge_q < EDGE_W'(MIN_EDGES)) || (edge_q > EDGE_W'(MAX_EDGES)));

  always_ff @(posedge clk) begin
    if (!rst_n || hold_i) begin
      win_q  <= '0;
      edge_q <= '0;
    end else if (win_end) begin
      win_q  <= '0;
      edge_q <= '0;
    end else begin
      win_q <= win_q + 1'b1;
      if (rise_i && edge_q != SAT) edge_q <= edge_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= (fail_q & ~clr_i) | bad;
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/pwm_delay_unit.sv
module pwm_delay_unit
  import pwm_mon_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int UNIT   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              req_i,
  output logic              dly_o
);
  localparam int MAX_TGT = ((1 << CODE_W) - 1) * UNIT;
  localparam int TGT_W   = cnt_width(MAX_TGT);

  logic             req_q;
  logic             pend_q;
  logic             busy_q;
  logic             dly_q;
  logic [TGT_W-1:0] cnt_q;
  logic [TGT_W-1:0] target;
  logic             chg;

  assign target = TGT_W'(code_i) * TGT_W'(UNIT);
  assign chg    = (req_i != req_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      dly_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      req_q <= req_i;
      if (chg) begin
        pend_q <= req_i;
        cnt_q  <= '0;
        busy_q <= (code_i != '0);
        if (code_i == '0) dly_q <= req_i;
      end else if (busy_q && tick_i) begin
        if (cnt_q == target - 1'b1) begin
          dly_q  <= pend_q;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign dly_o = dly_q;
endmodule

// File: rtl/pwm_clkmon_delay.sv
module pwm_clkmon_delay
  import pwm_mon_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int UNIT      = 16,
  parameter int WIN_CYC   = 256,
  parameter int MIN_EDGES = 8,
  parameter int MAX_EDGES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk_i,
  input  logic              int_tick_i,
  input  logic              sel_int_i,
  input  logic [CODE_W-1:0] delay_code_i,
  input  logic              on_i,
  input  logic              pwm_req_i,
  input  logic              fail_clr_i,
  output logic              chan_drv_o,
  output logic              clk_fail_o
);
  tb_src_e src;
  logic    ref_rise;
  logic    pwm_tick;
  logic    dly_lvl;
  logic    fail;
  logic    drv_q;

  assign src      = tb_src_e'(sel_int_i);
  assign pwm_tick = (src == TB_INT) ? int_tick_i : ref_rise;

  ref_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ref_clk_i), .rise_o(ref_rise)
  );

  ref_freq_window #(
    .WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES), .MAX_EDGES(MAX_EDGES)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .hold_i(src == TB_INT), .rise_i(ref_rise),
    .clr_i(fail_clr_i), .fail_o(fail)
  );

  pwm_delay_unit #(.CODE_W(CODE_W), .UNIT(UNIT)) u_dly (
    .clk(clk), .rst_n(rst_n), .tick_i(pwm_tick), .code_i(delay_code_i),
    .req_i(pwm_req_i), .dly_o(dly_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= fail ? on_i : dly_lvl;
  end

  assign chan_drv_o = drv_q;
  assign clk_fail_o = fail;
endmodule

// File: rtl/pwm_clkmon_delay_chk.sv
module pwm_clkmon_delay_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_int_i,
  input logic on_i,
  input logic pwm_req_i,
  input logic fail_clr_i,
  input logic chan_drv_o,
  input logic clk_fail_o,
  input logic pwm_tick,
  input logic dly_lvl,
  input logic req_prev
);
  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fail_o && !fail_clr_i) |=> clk_fail_o);

  // R9
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_clr_i && sel_int_i) |=> !clk_fail_o);

  // R10
  fail_only_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_fail_o) |-> !$past(sel_int_i));

  // R11
  bypass_follows_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_fail_o) |-> (chan_drv_o == $past(on_i)));

  // R3
  dly_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dly_lvl) |-> ($past(pwm_tick) || ($past(pwm_req_i) != $past(req_prev))));
endmodule

bind pwm_clkmon_delay pwm_clkmon_delay_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_int_i(sel_int_i), .on_i(on_i),
  .pwm_req_i(pwm_req_i), .fail_clr_i(fail_clr_i), .chan_drv_o(chan_drv_o),
  .clk_fail_o(clk_fail_o), .pwm_tick(pwm_tick), .dly_lvl(dly_lvl),
  .req_prev(u_dly.req_q)
);

// File: tb/pwm_clkmon_delay_bench.sv
module pwm_clkmon_delay_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk_i = 1'b0;
  logic       int_tick_i = 1'b0;
  logic       sel_int_i = 1'b1;
  logic [2:0] delay_code_i = 3'd0;
  logic       on_i = 1'b0;
  logic       pwm_req_i = 1'b0;
  logic       fail_clr_i = 1'b0;
  logic       chan_drv_o;
  logic       clk_fail_o;

  int n_chk = 0;
  int n_fail = 0;
  int ref_half = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_clkmon_delay u_pwm_clkmon_delay (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk_i), .int_tick_i(int_tick_i),
    .sel_int_i(sel_int_i), .delay_code_i(delay_code_i), .on_i(on_i),
    .pwm_req_i(pwm_req_i), .fail_clr_i(fail_clr_i), .chan_drv_o(chan_drv_o),
    .clk_fail_o(clk_fail_o)
  );

  // reference generator, half-period in system cycles, 0 = stopped
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      if (ref_half != 0) begin
        c++;
        if (c >= ref_half) begin
          c = 0;
          ref_clk_i = ~ref_clk_i;
        end
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      int_tick_i = 1'b1; cyc(1);
      int_tick_i = 1'b0; cyc(1);
    end
  endtask

  task automatic t_reset;
    cyc(3); rst_n = 1'b1; cyc(1);
    check("R1 chan", chan_drv_o, 1'b0);
    check("R1 fail", clk_fail_o, 1'b0);
  endtask

  task automatic t_nodelay;
    delay_code_i = 3'd0;
    pwm_req_i = 1'b1; cyc(1);
    check("R2 not before 2 cycles", chan_drv_o, 1'b0);
    cyc(1); check("R2 rise", chan_drv_o, 1'b1);
    pwm_req_i = 1'b0; cyc(2);
    check("R2 fall", chan_drv_o, 1'b0);
  endtask

  task automatic t_delay3;
    delay_code_i = 3'd3;
    pwm_req_i = 1'b1; cyc(2);
    ticks(47);
    check("R3 held before tick 48", chan_drv_o, 1'b0);
    ticks(1); cyc(1);
    check("R3 after 48 ticks", chan_drv_o, 1'b1);
  endtask

  task automatic t_restart;
    delay_code_i = 3'd1;
    pwm_req_i = 1'b0; cyc(2);
    ticks(16); cyc(1);
    check("R4 setup low", chan_drv_o, 1'b0);
    pwm_req_i = 1'b1; cyc(2);
    ticks(10);
    pwm_req_i = 1'b0; cyc(1);
    pwm_req_i = 1'b1; cyc(2);
    ticks(10); cyc(1);
    check("R4 restarted count", chan_drv_o, 1'b0);
    ticks(6); cyc(1);
    check("R4 after 16 fresh ticks", chan_drv_o, 1'b1);
  endtask

  task automatic t_select_int;
    pwm_req_i = 1'b0; cyc(2);
    ref_half = 2; cyc(200);
    check("R5 reference edges ignored", chan_drv_o, 1'b1);
    check("R10 fast reference unmonitored", clk_fail_o, 1'b0);
    ref_half = 0; cyc(4);
    ticks(16); cyc(1);
    check("R5 internal ticks used", chan_drv_o, 1'b0);
  endtask

  task automatic t_unmonitored;
    cyc(700);
    check("R10 stopped reference", clk_fail_o, 1'b0);
  endtask

  task automatic t_ref_timebase;
    ref_half = 8; cyc(40);
    sel_int_i = 1'b0; cyc(700);
    check("R8 in-window reference", clk_fail_o, 1'b0);
    pwm_req_i = 1'b1; cyc(200);
    check("R5 ref timebase not yet", chan_drv_o, 1'b0);
    cyc(120);
    check("R5 ref timebase reached", chan_drv_o, 1'b1);
    check("R8 still no fail", clk_fail_o, 1'b0);
  endtask

  task automatic t_slow;
    ref_half = 32; cyc(600);
    check("R6 slow reference", clk_fail_o, 1'b1);
  endtask

  task automatic t_bypass;
    on_i = 1'b0; cyc(2);
    check("R11 on low", chan_drv_o, 1'b0);
    on_i = 1'b1; cyc(1);
    check("R11 on high", chan_drv_o, 1'b1);
    pwm_req_i = 1'b0; delay_code_i = 3'd0; on_i = 1'b1; cyc(3);
    check("R11 request ignored", chan_drv_o, 1'b1);
    on_i = 1'b0; cyc(1);
    check("R11 on low again", chan_drv_o, 1'b0);
  endtask

  task automatic t_sticky;
    sel_int_i = 1'b1; ref_half = 0; cyc(50);
    check("R9 sticky", clk_fail_o, 1'b1);
    fail_clr_i = 1'b1; cyc(1); fail_clr_i = 1'b0;
    check("R9 cleared", clk_fail_o, 1'b0);
  endtask

  task automatic t_fast;
    ref_half = 2; cyc(20);
    sel_int_i = 1'b0; cyc(600);
    check("R7 fast reference", clk_fail_o, 1'b1);
    sel_int_i = 1'b1; ref_half = 0;
    fail_clr_i = 1'b1; cyc(1); fail_clr_i = 1'b0;
    check("R9 cleared after fast", clk_fail_o, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_nodelay();
    t_delay3();
    t_restart();
    t_select_int();
    t_unmonitored();
    t_ref_timebase();
    t_slow();
    t_bypass();
    t_sticky();
    t_fast();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule